// File: doc/BRIEF.md
# Buck Converter Fault Supervisor

This block watches a step-down regulator through a set of digital comparator flags and decides when the power stage must be overridden. The flags report feedback under the undervoltage threshold, feedback over the overvoltage threshold, feedback under the low crowbar-release level, and the soft-start ramp past its arming level. Further flags report overcurrent, die over-temperature and die recovered. Every flag is brought into the clock domain through a two-flop synchroniser. Undervoltage and overvoltage are then filtered by consecutive-cycle counters of different lengths.

A confirmed overvoltage clamps the output at once. The high-side switch is forced off and the low-side switch is forced on. The clamp holds until feedback falls under the release level, and it works even during soft-start. Undervoltage, overcurrent, and an overvoltage seen once soft-start is armed all set a fault latch that shuts the converter down. The latch holds until reset, or, when the restart mode selects it, clears after a parameterised delay and emits a one-cycle soft-start restart pulse. A two-flag thermal shutdown with hysteresis and a sticky code naming the first fault complete the outputs.

Top module: `buck_fault_sup`

## Requirements
- R1: Synchronous active-low reset clears the fault latch, the cause code (00), the crowbar, the thermal state and all counters. While enable is low (including right after reset) shutdown and high-side-off read 1, and low-side-on, fault and restart read 0.
- R2: An undervoltage fault needs the undervoltage flag high for UV_CYC (default 16) consecutive synchronised cycles. Any low cycle restarts the count, so UV_CYC-1 cycles never trip.
- R3: Undervoltage never sets the fault latch while soft-start has not armed since the last enable or restart.
- R4: An overvoltage flag held for OV_CYC (default 2) consecutive synchronised cycles, with enable high, forces high-side-off=1 and low-side-on=1. A single-cycle flag has no effect.
- R5: The crowbar ends in the cycle after the synchronised release flag is seen high, dropping low-side-on.
- R6: An overvoltage before soft-start is armed crowbars without setting the fault latch. Once armed, a confirmed overvoltage also sets the fault latch.
- R7: While the fault latch is set, or enable is low, shutdown and high-side-off are 1.
- R8: With restart mode low (latch-off), a set fault latch stays set until reset.
- R9: With restart mode high, the fault latch stays set for exactly RESTART_CYC cycles. It then clears, a one-cycle restart pulse is issued, and arming must be seen again.
- R10: The cause code records only the first fault since reset (01 undervoltage, 10 overvoltage, 11 overcurrent); later faults, including after an automatic restart, leave it unchanged.
- R11: Over-temperature forces shutdown. Shutdown is released only when the recovered flag is high and the over-temperature flag is low; with both flags low the shutdown stays.
- R12: Overcurrent with enable high sets the fault latch without debounce, even from a single-cycle flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_i | input | 1 | Converter enable |
| auto_rst_i | input | 1 | 1 = timed automatic restart, 0 = latch-off |
| ss_ok_i | input | 1 | Soft-start ramp above arming level |
| fb_uv_i | input | 1 | Feedback below undervoltage threshold |
| fb_ov_i | input | 1 | Feedback above overvoltage threshold |
| fb_rel_i | input | 1 | Feedback below crowbar release level |
| ocp_i | input | 1 | Overcurrent detected |
| hot_i | input | 1 | Die above shutdown temperature |
| cool_i | input | 1 | Die below recovery temperature |
| shutdown_o | output | 1 | Converter must stop switching |
| hs_off_o | output | 1 | Force high-side switch off |
| ls_on_o | output | 1 | Force low-side switch on (crowbar) |
| fault_o | output | 1 | Fault latch state |
| cause_o | output | 2 | First fault code |
| ss_restart_o | output | 1 | One-cycle soft-start restart pulse |

## Verification
Every raw flag spends two edges in the synchroniser. Any effect that needs no debounce therefore appears on the third edge after the flag is driven: the fault from overcurrent, the thermal state, and the crowbar release. A debounced condition needs N further edges for its counter, so the crowbar shows on edge OV_CYC+3 and the undervoltage fault on edge UV_CYC+3. The bench drives inputs on the falling edge and samples one nanosecond after a rising edge. At the exact boundaries it checks that the output has not moved one edge early and has moved on the due edge; the restart timer is checked the same way at RESTART_CYC-1 and RESTART_CYC edges after the fault. The vector table holds each pattern long enough for all latencies to elapse before its single check.

// File: rtl/bfs_pkg.sv
package bfs_pkg;

    typedef enum logic [1:0] {
        CAUSE_NONE = 2'b00,
        CAUSE_UV   = 2'b01,
        CAUSE_OV   = 2'b10,
        CAUSE_OC   = 2'b11
    } cause_e;

    // positions of the flags in the synchroniser vector
    localparam int IDX_EN   = 0;
    localparam int IDX_AUTO = 1;
    localparam int IDX_SS   = 2;
    localparam int IDX_UV   = 3;
    localparam int IDX_OV   = 4;
    localparam int IDX_REL  = 5;
    localparam int IDX_OC   = 6;
    localparam int IDX_HOT  = 7;
    localparam int IDX_COOL = 8;
    localparam int N_FLAGS  = 9;

endpackage

// File: rtl/bfs_sync.sv
module bfs_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] meta_q, meta_d;
    logic [W-1:0] safe_q, safe_d;

    always_comb begin
        meta_d = d_i;
        safe_d = meta_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            safe_q <= '0;
        end else begin
            meta_q <= meta_d;
            safe_q <= safe_d;
        end
    end

    assign q_o = safe_q;

endmodule

// File: rtl/bfs_debounce.sv
module bfs_debounce #(
    parameter int LEN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic flag_i,
    output logic hit_o
);

    localparam int CW = $clog2(LEN + 1);
    localparam logic [CW-1:0] TOP = CW'(LEN);

    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        if (!flag_i)
            cnt_d = '0;
        else if (cnt_q == TOP)
            cnt_d = cnt_q;
        else
            cnt_d = cnt_q + CW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign hit_o = (cnt_q == TOP);

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= TOP); // R2
    AST_CNT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_i |=> (cnt_q == '0)); // R2

endmodule

// File: rtl/buck_fault_sup.sv
module buck_fault_sup
    import bfs_pkg::*;
#(
    parameter int UV_CYC      = 16,
    parameter int OV_CYC      = 2,
    parameter int RESTART_CYC = 1000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_i,
    input  logic       auto_rst_i,
    input  logic       ss_ok_i,
    input  logic       fb_uv_i,
    input  logic       fb_ov_i,
    input  logic       fb_rel_i,
    input  logic       ocp_i,
    input  logic       hot_i,
    input  logic       cool_i,
    output logic       shutdown_o,
    output logic       hs_off_o,
    output logic       ls_on_o,
    output logic       fault_o,
    output logic [1:0] cause_o,
    output logic       ss_restart_o
);

    localparam int TW = (RESTART_CYC > 2) ? $clog2(RESTART_CYC) : 1;
    localparam logic [TW-1:0] T_END = TW'(RESTART_CYC - 1);

    typedef struct packed {
        logic          armed;
        logic          crowbar;
        logic          fault;
        cause_e        cause;
        logic          hot;
        logic [TW-1:0] tmr;
        logic          restart;
    } st_t;

    logic [N_FLAGS-1:0] raw, syn;
    logic en_s, auto_s, ss_s, uv_s, ov_s, rel_s, oc_s, hot_s, cool_s;
    logic uv_hit, ov_hit;
    logic uv_trip, ov_trip, oc_trip, any_trip;
    st_t  s_d, s_q;

    always_comb begin
        raw           = '0;
        raw[IDX_EN]   = en_i;
        raw[IDX_AUTO] = auto_rst_i;
        raw[IDX_SS]   = ss_ok_i;
        raw[IDX_UV]   = fb_uv_i;
        raw[IDX_OV]   = fb_ov_i;
        raw[IDX_REL]  = fb_rel_i;
        raw[IDX_OC]   = ocp_i;
        raw[IDX_HOT]  = hot_i;
        raw[IDX_COOL] = cool_i;
    end

    bfs_sync #(.W(N_FLAGS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw),
        .q_o   (syn)
    );

    assign en_s   = syn[IDX_EN];
    assign auto_s = syn[IDX_AUTO];
    assign ss_s   = syn[IDX_SS];
    assign uv_s   = syn[IDX_UV];
    assign ov_s   = syn[IDX_OV];
    assign rel_s  = syn[IDX_REL];
    assign oc_s   = syn[IDX_OC];
    assign hot_s  = syn[IDX_HOT];
    assign cool_s = syn[IDX_COOL];

    bfs_debounce #(.LEN(UV_CYC)) u_uv_deb (
        .clk    (clk),
        .rst_n  (rst_n),
        .flag_i (uv_s),
        .hit_o  (uv_hit)
    );

    bfs_debounce #(.LEN(OV_CYC)) u_ov_deb (
        .clk    (clk),
        .rst_n  (rst_n),
        .flag_i (ov_s),
        .hit_o  (ov_hit)
    );

    always_comb begin
        uv_trip  = en_s && s_q.armed && uv_hit;
        ov_trip  = en_s && s_q.armed && ov_hit;
        oc_trip  = en_s && oc_s;
        any_trip = uv_trip || ov_trip || oc_trip;

        s_d         = s_q;
        s_d.restart = 1'b0;

        // soft-start arming
        if (!en_s)
            s_d.armed = 1'b0;
        else if (ss_s)
            s_d.armed = 1'b1;

        // crowbar: release level wins over a new trip
        if (s_q.crowbar && rel_s)
            s_d.crowbar = 1'b0;
        else if (en_s && ov_hit)
            s_d.crowbar = 1'b1;

        // thermal hysteresis
        if (hot_s)
            s_d.hot = 1'b1;
        else if (cool_s)
            s_d.hot = 1'b0;

        // first-fault code
        if (s_q.cause == CAUSE_NONE && any_trip) begin
            if (oc_trip)
                s_d.cause = CAUSE_OC;
            else if (ov_trip)
                s_d.cause = CAUSE_OV;
            else
                s_d.cause = CAUSE_UV;
        end

        // fault latch and restart timer
        if (!s_q.fault) begin
            s_d.tmr = '0;
            if (any_trip)
                s_d.fault = 1'b1;
        end else if (auto_s) begin
            if (s_q.tmr == T_END) begin
                s_d.fault   = 1'b0;
                s_d.tmr     = '0;
                s_d.restart = 1'b1;
                s_d.armed   = 1'b0;
            end else begin
                s_d.tmr = s_q.tmr + TW'(1);
            end
        end else begin
            s_d.tmr = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign shutdown_o   = s_q.fault || s_q.hot || !en_s;
    assign hs_off_o     = shutdown_o || s_q.crowbar;
    assign ls_on_o      = s_q.crowbar;
    assign fault_o      = s_q.fault;
    assign cause_o      = s_q.cause;
    assign ss_restart_o = s_q.restart;

    AST_FAULT_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.fault) |-> $past(oc_s || s_q.armed)); // R3
    AST_CROWBAR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.crowbar) |-> $past(ov_hit && en_s)); // R4
    AST_LS_WITH_HS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        ls_on_o |-> hs_off_o); // R4
    AST_CROWBAR_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(s_q.crowbar) |-> $past(rel_s)); // R5
    AST_FAULT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.fault |-> (shutdown_o && hs_off_o)); // R7
    AST_LATCH_OFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.fault && !auto_s) |=> s_q.fault); // R8
    AST_RESTART_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.restart |=> !s_q.restart); // R9
    AST_RESTART_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.restart |-> (!s_q.fault && !s_q.armed)); // R9
    AST_CAUSE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.cause != CAUSE_NONE) |=> $stable(s_q.cause)); // R10
    AST_HOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(s_q.hot) |-> $past(cool_s && !hot_s)); // R11

endmodule

// File: tb/sim_buck_fault_sup.sv
`timescale 1ns/1ps
module sim_buck_fault_sup;

    localparam int UVN = 16;
    localparam int OVN = 2;
    localparam int RSN = 40;
    localparam int NV  = 11;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    // pin order: [8]en [7]auto [6]ss [5]uv [4]ov [3]rel [2]oc [1]hot [0]cool
    logic [8:0] pins = '0;
    logic shutdown, hs_off, ls_on, fault, restart;
    logic [1:0] cause;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    buck_fault_sup #(.UV_CYC(UVN), .OV_CYC(OVN), .RESTART_CYC(RSN)) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .en_i         (pins[8]),
        .auto_rst_i   (pins[7]),
        .ss_ok_i      (pins[6]),
        .fb_uv_i      (pins[5]),
        .fb_ov_i      (pins[4]),
        .fb_rel_i     (pins[3]),
        .ocp_i        (pins[2]),
        .hot_i        (pins[1]),
        .cool_i       (pins[0]),
        .shutdown_o   (shutdown),
        .hs_off_o     (hs_off),
        .ls_on_o      (ls_on),
        .fault_o      (fault),
        .cause_o      (cause),
        .ss_restart_o (restart)
    );

    // {pins[8:0], hold[7:0], expected {shutdown,hs_off,ls_on,fault,cause[1:0]}}
    localparam logic [22:0] TAB [NV] = '{
        {9'b100001001, 8'd6,  6'b000000},   // R1 enabled, idle
        {9'b100010001, 8'd8,  6'b011000},   // R4 R6 crowbar before arming, no fault
        {9'b100001001, 8'd6,  6'b000000},   // R5 release level ends crowbar
        {9'b100101001, 8'd30, 6'b000000},   // R3 undervoltage while unarmed
        {9'b100000010, 8'd6,  6'b110000},   // R11 over-temperature
        {9'b100000000, 8'd6,  6'b110000},   // R11 neither flag: still off
        {9'b100000001, 8'd6,  6'b000000},   // R11 recovered
        {9'b000000001, 8'd6,  6'b110000},   // R7 enable low
        {9'b100000001, 8'd6,  6'b000000},   // R7 enable back
        {9'b101100001, 8'd25, 6'b110101},   // R2 armed undervoltage fault, code 01
        {9'b101000001, 8'd30, 6'b110101}    // R8 latch-off holds
    };

    function automatic logic [5:0] outs();
        return {shutdown, hs_off, ls_on, fault, cause};
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [8:0] p);
        @(negedge clk);
        pins = p;
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        pins  = '0;
        edges(3);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin : main
        // R1 reset state
        edges(3);
        chk("R1 reset outputs", {1'b0, restart, outs()}, {1'b0, 1'b0, 6'b110000});
        @(negedge clk);
        rst_n = 1'b1;

        // vector table
        for (int i = 0; i < NV; i++) begin
            drive(TAB[i][22:14]);
            edges(int'(TAB[i][13:6]));
            chk($sformatf("table row %0d (R1-tagged rows in comments)", i),
                {2'b00, outs()}, {2'b00, TAB[i][5:0]});
        end

        // R4 overvoltage debounce boundary
        do_reset();
        drive(9'b100001001);
        edges(6);
        drive(9'b100010001);
        @(negedge clk);
        pins = 9'b100000001;
        edges(8);
        chk("R4 one-cycle overvoltage ignored", {7'd0, ls_on}, 8'd0);
        drive(9'b100010001);
        edges(OVN + 2);
        chk("R4 crowbar not yet", {7'd0, ls_on}, 8'd0);
        edges(1);
        chk("R4 crowbar due", {6'd0, hs_off, ls_on}, 8'd3);
        chk("R6 no fault while unarmed", {7'd0, fault}, 8'd0);
        drive(9'b100001001);
        edges(2);
        chk("R5 release not yet", {7'd0, ls_on}, 8'd1);
        edges(1);
        chk("R5 release due", {7'd0, ls_on}, 8'd0);

        // R2 undervoltage debounce boundary
        drive(9'b101000001);
        edges(6);
        drive(9'b101100001);
        repeat (UVN - 2) @(posedge clk);
        @(negedge clk);
        pins = 9'b101000001;
        edges(6);
        chk("R2 short undervoltage ignored", {7'd0, fault}, 8'd0);
        drive(9'b101100001);
        edges(UVN + 2);
        chk("R2 undervoltage not yet", {7'd0, fault}, 8'd0);
        edges(1);
        chk("R2 undervoltage due", {6'd0, cause}, 8'h01);

        // R6 armed overvoltage fault
        do_reset();
        drive(9'b101000001);
        edges(6);
        drive(9'b101010001);
        edges(8);
        chk("R6 armed overvoltage", {2'b00, outs()}, {2'b00, 6'b111110});
        drive(9'b101001001);
        edges(6);
        chk("R8 R5 clamp off, fault held", {2'b00, outs()}, {2'b00, 6'b110110});

        // R12 R9 R10 automatic restart
        do_reset();
        drive(9'b111000001);
        edges(6);
        drive(9'b111000101);
        @(posedge clk);
        @(negedge clk);
        pins = 9'b111000001;
        edges(2);
        chk("R12 overcurrent fault", {2'b00, outs()}, {2'b00, 6'b110111});
        edges(RSN - 1);
        chk("R9 fault still held", {6'd0, fault, restart}, 8'd2);
        edges(1);
        chk("R9 restart due", {6'd0, fault, restart}, 8'd1);
        edges(1);
        chk("R9 pulse one cycle", {7'd0, restart}, 8'd0);
        drive(9'b111010001);
        edges(10);
        chk("R10 first code kept", {5'd0, fault, cause}, {5'd0, 1'b1, 2'b11});

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule